// File: doc/BRIEF.md
# Pulse-Width Line Selector Receiver

This block decodes a single-wire pulse protocol that picks one of `N` output lines. The input is a level that has already been synchronised to the block clock. All widths are counted in clock cycles. A long high pulse starts a frame and clears the receiver. After that, each short high pulse moves a one-hot pointer up by one line. A long low level then commits the pointer: it loads a held one-hot output register and fires a single-cycle strobe on the chosen line.

There is no stream traffic at the edges of this block. The line is a raw level, and the outputs are a plain held register, a strobe and an error flag. So there is no valid/ready handshake and no back-pressure.

A pulse with a width outside the legal ranges, a step count past `N`, or a long low with no step before it raises a sticky error flag and sends the receiver back to idle. The committed output is not changed in any of these cases.

Top module: `pulse_select_rx`

## Requirements
- R1: The reset input is synchronous and active high. While it is asserted, and in the cycle after it is released, `sel_o`, `strobe_o` and `err_o` are all zero, and the receiver is idle. This holds even if reset arrives in the middle of a frame.
- R2: A high pulse of `LONG_CYCLES` or more cycles is a framing pulse, and any longer width counts the same. It is decoded at the clock edge that first samples the line low again. It arms the receiver, clears the pointer and discards any steps already counted.
- R3: While armed or counting, a high pulse of `MIN_CYCLES` to `SHORT_MAX` cycles is a step. The first step selects bit 0, and every later step shifts the one-hot pointer one position to the left. So k steps select bit k-1.
- R4: A low run that reaches `LONG_CYCLES` cycles, after at least one step, is a commit. Call the edge that samples the LONG_CYCLES-th low cycle edge E. The next edge, E+1, loads `sel_o` with the one-hot pointer. `sel_o` is unchanged just after edge E.
- R5: `strobe_o` equals the new `sel_o` for exactly the one cycle after edge E+1. It is zero at every other time.
- R6: While armed or counting, a high pulse that is shorter than `MIN_CYCLES`, or that lasts from `SHORT_MAX`+1 to `LONG_CYCLES`-1 cycles, sets `err_o` at its falling-edge sample and returns the receiver to idle.
- R7: A step that arrives when the pointer already sits on bit `N`-1 sets `err_o` and returns the receiver to idle.
- R8: A low run of `LONG_CYCLES` cycles while armed, with no step before it, sets `err_o` and returns the receiver to idle. No commit happens.
- R9: `sel_o` changes only on a valid commit. In the idle state, short high pulses and low runs of any length leave `sel_o`, `strobe_o` and `err_o` unchanged. After an error, no commit happens until a new frame starts.
- R10: `err_o` stays set until the next framing pulse or a reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_i | input | 1 | Synchronous reset, active high |
| line_i | input | 1 | Synchronised serial line level |
| sel_o | output | N | Held one-hot committed selection (bit i = i+1 steps) |
| strobe_o | output | N | One-cycle strobe on the committed line |
| err_o | output | 1 | Sticky protocol error flag |

## Verification
Each high pulse is decoded at the edge that first samples the line low again. So the error flag and any change to the pointer are visible right after that edge.

A commit takes effect one edge later than the edge that samples the LONG_CYCLES-th low cycle. The bench checks `sel_o` at three points: just after that edge, where it must still hold the old value; one cycle later, together with the strobe; and one cycle after that, when the strobe must be low again.

All stimulus is driven on falling clock edges. Each hold step lasts a whole number of clock cycles, so the bench always knows which rising edge made each decision.

// File: rtl/psr_pkg.sv
package psr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_COUNT = 2'd2,
    ST_COMMIT = 2'd3
  } rx_state_e;

  typedef enum logic [2:0] {
    PC_NONE   = 3'd0,
    PC_FRAME  = 3'd1,
    PC_STEP   = 3'd2,
    PC_BADHI  = 3'd3,
    PC_LONGLO = 3'd4
  } pulse_class_e;

endpackage

// File: rtl/psr_run_meter.sv
module psr_run_meter #(
  parameter int LONG_CYCLES = 8,
  parameter int RW = $clog2(LONG_CYCLES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          line_i,
  output logic          lvl_o,
  output logic [RW-1:0] run_o
);
  localparam logic [RW-1:0] RUN_SAT = RW'(LONG_CYCLES);
  localparam logic [RW-1:0] RUN_ONE = RW'(1);

  logic          lvl_q;
  logic [RW-1:0] run_q;

  // run_q counts consecutive samples at lvl_q, saturating at LONG_CYCLES
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      lvl_q <= 1'b0;
      run_q <= '0;
    end else if (line_i != lvl_q) begin
      lvl_q <= line_i;
      run_q <= RUN_ONE;
    end else if (run_q != RUN_SAT) begin
      run_q <= run_q + RUN_ONE;
    end
  end

  assign lvl_o = lvl_q;
  assign run_o = run_q;

  assert_run_bound_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    run_q <= RUN_SAT);

  assert_run_restart_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (line_i != lvl_q) |=> (run_q == RUN_ONE));

endmodule

// File: rtl/psr_classify.sv
module psr_classify
  import psr_pkg::*;
#(
  parameter int MIN_CYCLES  = 2,
  parameter int SHORT_MAX   = 4,
  parameter int LONG_CYCLES = 8,
  parameter int RW = $clog2(LONG_CYCLES + 1)
) (
  input  logic          line_i,
  input  logic          lvl_i,
  input  logic [RW-1:0] run_i,
  output pulse_class_e  cls_o
);
  localparam logic [RW-1:0] W_MIN  = RW'(MIN_CYCLES);
  localparam logic [RW-1:0] W_SMAX = RW'(SHORT_MAX);
  localparam logic [RW-1:0] W_LONG = RW'(LONG_CYCLES);
  localparam logic [RW-1:0] W_LAST = RW'(LONG_CYCLES - 1);

  always_comb begin
    cls_o = PC_NONE;
    if (lvl_i && !line_i) begin
      // a high pulse just ended; run_i holds its width
      if (run_i >= W_LONG)
        cls_o = PC_FRAME;
      else if (run_i >= W_MIN && run_i <= W_SMAX)
        cls_o = PC_STEP;
      else
        cls_o = PC_BADHI;
    end else if (!lvl_i && !line_i && run_i == W_LAST) begin
      // this edge samples the LONG_CYCLES-th low cycle
      cls_o = PC_LONGLO;
    end
  end

endmodule

// File: rtl/psr_pointer.sv
module psr_pointer #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         clr_i,
  input  logic         step_i,
  output logic [N-1:0] ptr_o,
  output logic         full_o
);
  logic [N-1:0] ptr_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i)
      ptr_q <= '0;
    else if (step_i) begin
      if (ptr_q == '0)
        ptr_q <= {{(N-1){1'b0}}, 1'b1};
      else
        ptr_q <= ptr_q << 1;
    end
  end

  assign ptr_o  = ptr_q;
  assign full_o = ptr_q[N-1];

  assert_ptr_onehot_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(ptr_q));

  assert_ptr_shift_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (step_i && !clr_i && ptr_q != '0 && !ptr_q[N-1]) |=> (ptr_q == ($past(ptr_q) << 1)));

  assert_ptr_first_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (step_i && !clr_i && ptr_q == '0) |=> (ptr_q == {{(N-1){1'b0}}, 1'b1}));

endmodule

// File: rtl/psr_commit.sv
module psr_commit #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         load_i,
  input  logic [N-1:0] val_i,
  output logic [N-1:0] sel_o,
  output logic [N-1:0] strobe_o
);
  logic [N-1:0] sel_q;
  logic [N-1:0] stb_q;

  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        sel_q[i] <= 1'b0;
        stb_q[i] <= 1'b0;
      end else begin
        stb_q[i] <= load_i & val_i[i];
        if (load_i)
          sel_q[i] <= val_i[i];
      end
    end
  end

  assign sel_o    = sel_q;
  assign strobe_o = stb_q;

  assert_strobe_single_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (stb_q != '0) |=> (stb_q == '0));

  assert_strobe_matches_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (stb_q != '0) |-> (stb_q == sel_q));

  assert_sel_onehot_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(sel_q));

endmodule

// File: rtl/pulse_select_rx.sv
module pulse_select_rx
  import psr_pkg::*;
#(
  parameter int N           = 4,
  parameter int MIN_CYCLES  = 2,
  parameter int SHORT_MAX   = 4,
  parameter int LONG_CYCLES = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         line_i,
  output logic [N-1:0] sel_o,
  output logic [N-1:0] strobe_o,
  output logic         err_o
);
  localparam int RW = $clog2(LONG_CYCLES + 1);

  initial begin
    if (N < 2 || MIN_CYCLES < 1 || SHORT_MAX < MIN_CYCLES || LONG_CYCLES <= SHORT_MAX + 1)
      $error("pulse_select_rx: inconsistent width parameters");
  end

  logic          lvl;
  logic [RW-1:0] run;
  pulse_class_e  cls;
  logic [N-1:0]  ptr;
  logic          ptr_full;

  rx_state_e state_q, state_d;
  logic      err_q;
  logic      ptr_clr, ptr_step, err_set, err_clr, do_load;

  psr_run_meter #(.LONG_CYCLES(LONG_CYCLES), .RW(RW)) meter_i (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .line_i(line_i),
    .lvl_o (lvl),
    .run_o (run)
  );

  psr_classify #(
    .MIN_CYCLES(MIN_CYCLES), .SHORT_MAX(SHORT_MAX),
    .LONG_CYCLES(LONG_CYCLES), .RW(RW)
  ) classify_i (
    .line_i(line_i),
    .lvl_i (lvl),
    .run_i (run),
    .cls_o (cls)
  );

  psr_pointer #(.N(N)) pointer_i (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .clr_i (ptr_clr),
    .step_i(ptr_step),
    .ptr_o (ptr),
    .full_o(ptr_full)
  );

  psr_commit #(.N(N)) commit_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .load_i  (do_load),
    .val_i   (ptr),
    .sel_o   (sel_o),
    .strobe_o(strobe_o)
  );

  always_comb begin
    state_d  = state_q;
    ptr_clr  = 1'b0;
    ptr_step = 1'b0;
    err_set  = 1'b0;
    err_clr  = 1'b0;
    do_load  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cls == PC_FRAME) begin
          state_d = ST_ARMED;
          ptr_clr = 1'b1;
          err_clr = 1'b1;
        end
      end
      ST_ARMED: begin
        unique case (cls)
          PC_FRAME: begin
            ptr_clr = 1'b1;
            err_clr = 1'b1;
          end
          PC_STEP: begin
            ptr_step = 1'b1;
            state_d  = ST_COUNT;
          end
          PC_BADHI, PC_LONGLO: begin
            err_set = 1'b1;
            ptr_clr = 1'b1;
            state_d = ST_IDLE;
          end
          default: ;
        endcase
      end
      ST_COUNT: begin
        unique case (cls)
          PC_FRAME: begin
            ptr_clr = 1'b1;
            err_clr = 1'b1;
            state_d = ST_ARMED;
          end
          PC_STEP: begin
            if (ptr_full) begin
              err_set = 1'b1;
              ptr_clr = 1'b1;
              state_d = ST_IDLE;
            end else begin
              ptr_step = 1'b1;
            end
          end
          PC_BADHI: begin
            err_set = 1'b1;
            ptr_clr = 1'b1;
            state_d = ST_IDLE;
          end
          PC_LONGLO: state_d = ST_COMMIT;
          default: ;
        endcase
      end
      ST_COMMIT: begin
        do_load = 1'b1;
        ptr_clr = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (err_set)
        err_q <= 1'b1;
      else if (err_clr)
        err_q <= 1'b0;
    end
  end

  assign err_o = err_q;

  assert_sel_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q != ST_COMMIT) |=> $stable(sel_o));

  assert_commit_nonzero_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == ST_COMMIT) |-> (ptr != '0));

  assert_err_idle_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(err_o) |-> (state_q == ST_IDLE));

  assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    (err_o && state_q == ST_IDLE && line_i == lvl) |=> err_o);

endmodule

// File: tb/pulse_select_rx_tb_top.sv
`timescale 1ns/100ps
module pulse_select_rx_tb_top;
  localparam int N = 4;
  localparam int MINW = 2;
  localparam int SMAX = 4;
  localparam int LONGW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line = 1'b0;
  logic [N-1:0] sel, stb;
  logic err;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] cur_sel = '0;

  always #2.5 clk = ~clk;

  pulse_select_rx #(.N(N), .MIN_CYCLES(MINW), .SHORT_MAX(SMAX), .LONG_CYCLES(LONGW)) dut_i (
    .clk_i(clk), .rst_i(rst), .line_i(line),
    .sel_o(sel), .strobe_o(stb), .err_o(err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // line held at v for exactly n rising edges; entered and left at a falling edge
  task automatic hold(input logic v, input int n);
    line = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input int fw);
    hold(1'b1, fw);
    hold(1'b0, 2);
  endtask

  task automatic steps(input int k, input int w, input int g);
    for (int i = 0; i < k; i++) begin
      hold(1'b1, w);
      if (i < k - 1) hold(1'b0, g);
    end
  endtask

  task automatic commit_expect(input logic [N-1:0] exp);
    hold(1'b0, LONGW);
    chk("R4 sel before load", 32'(sel), 32'(cur_sel));
    chk("R5 no early strobe", 32'(stb), 0);
    @(negedge clk);
    chk("R4 sel loaded", 32'(sel), 32'(exp));
    chk("R5 strobe on line", 32'(stb), 32'(exp));
    @(negedge clk);
    chk("R5 strobe one cycle", 32'(stb), 0);
    chk("R4 sel held", 32'(sel), 32'(exp));
    chk("R10 no error on commit", 32'(err), 0);
    cur_sel = exp;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 sel in reset", 32'(sel), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 sel after reset", 32'(sel), 0);
    chk("R1 strobe after reset", 32'(stb), 0);
    chk("R1 err after reset", 32'(err), 0);

    // R9: idle receiver ignores steps and long lows
    hold(1'b1, 3); hold(1'b0, 3); hold(1'b1, 1); hold(1'b0, LONGW + 4);
    chk("R9 idle sel", 32'(sel), 0);
    chk("R9 idle strobe", 32'(stb), 0);
    chk("R9 idle err", 32'(err), 0);

    // R2 R3 R4 R5 sweep: step count, step width, gap width, frame width
    for (int k = 1; k <= N; k++)
      for (int w = MINW; w <= SMAX; w++)
        for (int g = 1; g <= 2; g++) begin
          frame(LONGW + ((k + w + g) % 3));
          steps(k, w, g);
          commit_expect(N'(1) << (k - 1));
        end

    // R6: illegal high widths while armed (c=0) and while counting (c=1)
    for (int c = 0; c < 2; c++)
      for (int w = 1; w < LONGW; w++) begin
        if (w >= MINW && w <= SMAX) continue;
        frame(LONGW);
        if (c == 1) begin steps(1, MINW, 1); hold(1'b0, 1); end
        hold(1'b1, w);
        hold(1'b0, 1);
        chk("R6 err on bad width", 32'(err), 1);
        hold(1'b0, LONGW + 2);
        chk("R9 no commit after error", 32'(sel), 32'(cur_sel));
        chk("R9 no strobe after error", 32'(stb), 0);
        chk("R10 err sticky", 32'(err), 1);
        hold(1'b1, LONGW);
        hold(1'b0, 1);
        chk("R10 frame clears err", 32'(err), 0);
        hold(1'b0, 1);
      end

    // R7: one step past the last line
    frame(LONGW);
    steps(N, MINW, 1);
    hold(1'b0, 1);
    hold(1'b1, MINW);
    hold(1'b0, 1);
    chk("R7 err on overflow", 32'(err), 1);
    hold(1'b0, LONGW + 2);
    chk("R7 sel unchanged", 32'(sel), 32'(cur_sel));
    chk("R7 no strobe", 32'(stb), 0);

    // R8: long low with no step
    hold(1'b1, LONGW);
    hold(1'b0, LONGW);
    chk("R8 err on empty commit", 32'(err), 1);
    hold(1'b0, 3);
    chk("R8 sel unchanged", 32'(sel), 32'(cur_sel));

    // R2: reframe mid count discards earlier steps
    frame(LONGW);
    steps(3, SMAX, 2);
    hold(1'b0, 1);
    frame(LONGW + 1);
    steps(1, MINW, 1);
    commit_expect(N'(1));
    chk("R2 reframe selects bit0", 32'(sel), 1);
    frame(LONGW);
    steps(2, 3, 1);
    commit_expect(N'(2));

    // R1: reset in mid frame
    frame(LONGW);
    steps(2, MINW, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 mid reset sel", 32'(sel), 0);
    chk("R1 mid reset err", 32'(err), 0);
    cur_sel = '0;
    hold(1'b0, LONGW + 3);
    chk("R1 no commit after reset", 32'(sel), 0);
    chk("R1 no strobe after reset", 32'(stb), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule